// File: doc/BRIEF.md
# Paged Host Aperture Remapper

This block sits on the device side of a 1 MB host-visible memory aperture and lets the host reach a 32 MB internal address space. An aperture offset whose top bit is clear (0x00000 to 0x7FFFF) is sent to the same internal offset. An offset whose top bit is set (0x80000 to 0xFFFFF) is sent into one 512 KB page of the internal space. A 6-bit page number picks that page, and the page number is taken from a window control register that the block holds itself.

The window control register sits at a fixed offset in the identity-mapped half. It has a page field and an enable flag. The host writes it and can read it back to confirm the change. A new page number applies from the next accepted request. Upper-half accesses made while the enable flag is clear are not forwarded. Such a read returns a fixed marker value, such a write is discarded, and a sticky error output is raised.

The host side uses a valid/ready request with a single response pulse. The internal side uses a valid/ready request and a one-shot response that carries the read data. Only one request is in flight at a time.

Top module: `bar_window_remap`

## Requirements
- R1: After reset, `host_req_ready_o` is 1, `int_req_valid_o`, `host_rsp_valid_o` and `blk_err_o` are 0, and a read of the window control register returns 0 (page 0, enable flag clear).
- R2: A request to an aperture offset below 0x80000, other than the window control register, is forwarded with `int_req_addr_o` equal to that offset zero-extended to 25 bits.
- R3: With the enable flag set, a request to an aperture offset of 0x80000 or above is forwarded to internal address (page << 19) | (offset & 0x7FFFF).
- R4: The window control register sits at aperture offset `WIN_REG_OFS` (default 0x310C). It holds the page number in bits [5:0] and the enable flag in bit `EN_BIT` (30 or 31, default 31). It is served locally and never forwarded. A read returns the last written values of those bits, with all other bits 0.
- R5: A write to the window control register changes the mapping of the very next accepted request.
- R6: A request to the upper half while the enable flag is clear is not forwarded. A read returns 0xDEADBEEF, a write is discarded, and `blk_err_o` goes to 1 and stays at 1 until reset.
- R7: Only one request is outstanding. `host_req_ready_o` is 0 from the cycle after acceptance until the cycle after the single-cycle `host_rsp_valid_o` pulse, and it is 1 again in the cycle after that pulse.
- R8: A forwarded read returns the internal response data on `host_rsp_rdata_o`. A forwarded write carries `int_req_we_o`=1 and the host write data on `int_req_wdata_o`. A write response returns 0 as its data.
- R9: While `int_req_valid_o` is 1 and `int_req_ready_i` is 0, the internal request stays asserted with address, write flag and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_valid_i | input | 1 | Host request valid |
| host_req_ready_o | output | 1 | Block can accept a host request |
| host_req_addr_i | input | 20 | Aperture byte offset |
| host_req_we_i | input | 1 | 1 = write, 0 = read |
| host_req_wdata_i | input | 32 | Host write data |
| host_rsp_valid_o | output | 1 | Single-cycle response pulse |
| host_rsp_rdata_o | output | 32 | Read data (0 for writes) |
| blk_err_o | output | 1 | Sticky flag: an upper-half access was made while the window was disabled |
| int_req_valid_o | output | 1 | Internal request valid |
| int_req_ready_i | input | 1 | Internal fabric accepts request |
| int_req_addr_o | output | 25 | Internal byte address |
| int_req_we_o | output | 1 | Internal write flag |
| int_req_wdata_o | output | 32 | Internal write data |
| int_rsp_valid_i | input | 1 | Internal response (read data or write acknowledge) |
| int_rsp_rdata_i | input | 32 | Internal read data |

## Verification
The assertions assume that the internal fabric raises `int_rsp_valid_i` only after it has accepted a request, and only once per request. They also assume that the host drives the request fields in the cycle it is accepted. The bench's internal model meets these rules. It toggles `int_req_ready_i` on every cycle so that requests stall, and it answers exactly once, one cycle after each handshake. It never sends an unsolicited response. The host driver changes the request fields only when it is away from a clock edge and no request is pending, and it drops valid right after acceptance.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xfer_state_e;

  typedef enum logic [1:0] {
    CLS_FWD     = 2'd0,
    CLS_WINREG  = 2'd1,
    CLS_BLOCKED = 2'd2
  } req_cls_e;
endpackage

// File: rtl/bwr_win_reg.sv
module bwr_win_reg #(
  parameter int DW     = 32,
  parameter int WIN_W  = 6,
  parameter int EN_BIT = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [WIN_W-1:0] win_o,
  output logic             en_o,
  output logic [DW-1:0]    rdata_o
);
  logic [WIN_W-1:0] win_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_en_i) begin
      win_q <= wdata_i[WIN_W-1:0];
      en_q  <= wdata_i[EN_BIT];
    end
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[WIN_W-1:0]   = win_q;
    rdata_o[EN_BIT]      = en_q;
  end

  assign win_o = win_q;
  assign en_o  = en_q;

  AST_WIN_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (win_o == $past(wdata_i[WIN_W-1:0]) && en_o == $past(wdata_i[EN_BIT]))); // R4
  AST_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rdata_o)); // R4
endmodule

// File: rtl/bwr_decode.sv
module bwr_decode
  import bwr_pkg::*;
#(
  parameter int              HOST_AW     = 20,
  parameter int              WIN_W       = 6,
  parameter logic [HOST_AW-1:0] WIN_REG_OFS = 20'h0310C
) (
  input  logic [HOST_AW-1:0]         addr_i,
  input  logic [WIN_W-1:0]           win_i,
  input  logic                       win_en_i,
  output req_cls_e                   cls_o,
  output logic [WIN_W+HOST_AW-2:0]   int_addr_o
);
  localparam int PAGE_W = HOST_AW - 1;

  logic upper;
  assign upper = addr_i[HOST_AW-1];

  always_comb begin
    if (addr_i == WIN_REG_OFS)   cls_o = CLS_WINREG;
    else if (upper && !win_en_i) cls_o = CLS_BLOCKED;
    else                         cls_o = CLS_FWD;
  end

  // upper half: page number replaces the aperture's top bit
  assign int_addr_o = upper ? {win_i, addr_i[PAGE_W-1:0]}
                            : {{WIN_W{1'b0}}, addr_i[PAGE_W-1:0]};
endmodule

// File: rtl/bwr_xfer_ctrl.sv
module bwr_xfer_ctrl
  import bwr_pkg::*;
#(
  parameter int          DW            = 32,
  parameter int          INT_AW        = 25,
  parameter logic [31:0] BLOCKED_RDATA = 32'hDEADBEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_valid_i,
  output logic              host_req_ready_o,
  input  logic              host_req_we_i,
  input  logic [DW-1:0]     host_req_wdata_i,
  output logic              host_rsp_valid_o,
  output logic [DW-1:0]     host_rsp_rdata_o,
  output logic              blk_err_o,
  input  req_cls_e          cls_i,
  input  logic [INT_AW-1:0] int_addr_i,
  input  logic [DW-1:0]     win_rdata_i,
  output logic              win_wr_en_o,
  output logic              int_req_valid_o,
  input  logic              int_req_ready_i,
  output logic [INT_AW-1:0] int_req_addr_o,
  output logic              int_req_we_o,
  output logic [DW-1:0]     int_req_wdata_o,
  input  logic              int_rsp_valid_i,
  input  logic [DW-1:0]     int_rsp_rdata_i
);
  xfer_state_e       state_q;
  logic [INT_AW-1:0] addr_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rsp_q;
  logic              err_q;
  logic              accept;

  assign accept      = host_req_valid_i && (state_q == ST_IDLE);
  assign win_wr_en_o = accept && (cls_i == CLS_WINREG) && host_req_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rsp_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          unique case (cls_i)
            CLS_FWD: begin
              addr_q  <= int_addr_i;
              we_q    <= host_req_we_i;
              wdata_q <= host_req_wdata_i;
              state_q <= ST_ISSUE;
            end
            CLS_WINREG: begin
              rsp_q   <= host_req_we_i ? '0 : win_rdata_i;
              state_q <= ST_RESP;
            end
            default: begin
              rsp_q   <= host_req_we_i ? '0 : DW'(BLOCKED_RDATA);
              err_q   <= 1'b1;
              state_q <= ST_RESP;
            end
          endcase
        end
        ST_ISSUE: if (int_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (int_rsp_valid_i) begin
          rsp_q   <= we_q ? '0 : int_rsp_rdata_i;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign host_req_ready_o = (state_q == ST_IDLE);
  assign host_rsp_valid_o = (state_q == ST_RESP);
  assign host_rsp_rdata_o = rsp_q;
  assign blk_err_o        = err_q;
  assign int_req_valid_o  = (state_q == ST_ISSUE);
  assign int_req_addr_o   = addr_q;
  assign int_req_we_o     = we_q;
  assign int_req_wdata_o  = wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_valid_o && !int_req_ready_i) |=> (int_req_valid_o && $stable(int_req_addr_o)
      && $stable(int_req_we_o) && $stable(int_req_wdata_o))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_err_o |=> blk_err_o); // R6
  AST_BLOCKED_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cls_i == CLS_BLOCKED) |=> (host_rsp_valid_o && !int_req_valid_o && blk_err_o)); // R6
  AST_FWD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cls_i == CLS_FWD) |=> (int_req_valid_o && int_req_addr_o == $past(int_addr_i))); // R3
  AST_RSP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && int_rsp_valid_i && !we_q) |=>
      (host_rsp_valid_o && host_rsp_rdata_o == $past(int_rsp_rdata_i))); // R8
  AST_SINGLE_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rsp_valid_o |=> (!host_rsp_valid_o && host_req_ready_o)); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !host_req_ready_o); // R7
endmodule

// File: rtl/bar_window_remap.sv
module bar_window_remap
  import bwr_pkg::*;
#(
  parameter int                 HOST_AW       = 20,
  parameter int                 WIN_W         = 6,
  parameter int                 DW            = 32,
  parameter int                 EN_BIT        = 31,
  parameter logic [HOST_AW-1:0] WIN_REG_OFS   = 20'h0310C,
  parameter logic [31:0]        BLOCKED_RDATA = 32'hDEADBEEF,
  localparam int                INT_AW        = WIN_W + HOST_AW - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_valid_i,
  output logic               host_req_ready_o,
  input  logic [HOST_AW-1:0] host_req_addr_i,
  input  logic               host_req_we_i,
  input  logic [DW-1:0]      host_req_wdata_i,
  output logic               host_rsp_valid_o,
  output logic [DW-1:0]      host_rsp_rdata_o,
  output logic               blk_err_o,
  output logic               int_req_valid_o,
  input  logic               int_req_ready_i,
  output logic [INT_AW-1:0]  int_req_addr_o,
  output logic               int_req_we_o,
  output logic [DW-1:0]      int_req_wdata_o,
  input  logic               int_rsp_valid_i,
  input  logic [DW-1:0]      int_rsp_rdata_i
);
  logic [WIN_W-1:0]  win;
  logic              win_en;
  logic [DW-1:0]     win_rdata;
  logic              win_wr_en;
  req_cls_e          cls;
  logic [INT_AW-1:0] int_addr;

  bwr_win_reg #(.DW(DW), .WIN_W(WIN_W), .EN_BIT(EN_BIT)) win_reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (win_wr_en),
    .wdata_i (host_req_wdata_i),
    .win_o   (win),
    .en_o    (win_en),
    .rdata_o (win_rdata)
  );

  bwr_decode #(.HOST_AW(HOST_AW), .WIN_W(WIN_W), .WIN_REG_OFS(WIN_REG_OFS)) decode_i (
    .addr_i     (host_req_addr_i),
    .win_i      (win),
    .win_en_i   (win_en),
    .cls_o      (cls),
    .int_addr_o (int_addr)
  );

  bwr_xfer_ctrl #(.DW(DW), .INT_AW(INT_AW), .BLOCKED_RDATA(BLOCKED_RDATA)) ctrl_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .host_req_valid_i (host_req_valid_i),
    .host_req_ready_o (host_req_ready_o),
    .host_req_we_i    (host_req_we_i),
    .host_req_wdata_i (host_req_wdata_i),
    .host_rsp_valid_o (host_rsp_valid_o),
    .host_rsp_rdata_o (host_rsp_rdata_o),
    .blk_err_o        (blk_err_o),
    .cls_i            (cls),
    .int_addr_i       (int_addr),
    .win_rdata_i      (win_rdata),
    .win_wr_en_o      (win_wr_en),
    .int_req_valid_o  (int_req_valid_o),
    .int_req_ready_i  (int_req_ready_i),
    .int_req_addr_o   (int_req_addr_o),
    .int_req_we_o     (int_req_we_o),
    .int_req_wdata_o  (int_req_wdata_o),
    .int_rsp_valid_i  (int_rsp_valid_i),
    .int_rsp_rdata_i  (int_rsp_rdata_i)
  );

  logic accept_top;
  assign accept_top = host_req_valid_i && host_req_ready_o;

  AST_LOWER_IDENTITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_top && !host_req_addr_i[HOST_AW-1] && host_req_addr_i != WIN_REG_OFS) |=>
      (int_req_valid_o && int_req_addr_o == INT_AW'($past(host_req_addr_i)))); // R2
  AST_WINREG_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_top && host_req_addr_i == WIN_REG_OFS) |=> (host_rsp_valid_o && !int_req_valid_o)); // R4
endmodule

// File: tb/bar_window_remap_tb.sv
module bar_window_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0;
  logic        h_ready;
  logic [19:0] h_addr = '0;
  logic        h_we = 1'b0;
  logic [31:0] h_wdata = '0;
  logic        h_rsp_valid;
  logic [31:0] h_rsp_rdata;
  logic        blk_err;
  logic        i_valid;
  logic        i_ready = 1'b0;
  logic [24:0] i_addr;
  logic        i_we;
  logic [31:0] i_wdata;
  logic        i_rsp_valid = 1'b0;
  logic [31:0] i_rsp_rdata = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int fwd_cnt = 0;
  int hold_err = 0;
  logic [24:0] last_addr = '0;
  logic        last_we = 1'b0;
  logic [31:0] last_wdata = '0;
  logic        prev_stall = 1'b0;
  logic [24:0] prev_addr = '0;

  always #2 clk = ~clk;

  bar_window_remap dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .host_req_valid_i (h_valid),
    .host_req_ready_o (h_ready),
    .host_req_addr_i  (h_addr),
    .host_req_we_i    (h_we),
    .host_req_wdata_i (h_wdata),
    .host_rsp_valid_o (h_rsp_valid),
    .host_rsp_rdata_o (h_rsp_rdata),
    .blk_err_o        (blk_err),
    .int_req_valid_o  (i_valid),
    .int_req_ready_i  (i_ready),
    .int_req_addr_o   (i_addr),
    .int_req_we_o     (i_we),
    .int_req_wdata_o  (i_wdata),
    .int_rsp_valid_i  (i_rsp_valid),
    .int_rsp_rdata_i  (i_rsp_rdata)
  );

  // internal fabric model: stalls every other cycle, answers one cycle after handshake
  always @(posedge clk) begin
    cycles      <= cycles + 1;
    i_ready     <= ~i_ready;
    i_rsp_valid <= 1'b0;
    if (prev_stall && i_addr != prev_addr) hold_err <= hold_err + 1;
    prev_stall <= i_valid && !i_ready;
    prev_addr  <= i_addr;
    if (i_valid && i_ready) begin
      fwd_cnt     <= fwd_cnt + 1;
      last_addr   <= i_addr;
      last_we     <= i_we;
      last_wdata  <= i_wdata;
      i_rsp_valid <= 1'b1;
      i_rsp_rdata <= {7'h0, i_addr} ^ 32'h5A000000;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [19:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    h_valid = 1'b1; h_we = we; h_addr = a; h_wdata = d;
    while (!h_ready) @(negedge clk);
    @(negedge clk);
    h_valid = 1'b0;
    while (!h_rsp_valid) @(negedge clk);
    rd = h_rsp_rdata;
  endtask

  typedef struct packed {
    logic        we;
    logic [19:0] addr;
    logic [31:0] wdata;
    logic        fwd;
    logic [24:0] eaddr;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 20'h0310C, 32'h80000005, 1'b0, 25'h0,       32'h0},
    '{1'b0, 20'h0310C, 32'h0,        1'b0, 25'h0,       32'h80000005},
    '{1'b0, 20'h00010, 32'h0,        1'b1, 25'h10,      32'h5A000010},
    '{1'b0, 20'h7FFFC, 32'h0,        1'b1, 25'h7FFFC,   32'h5A07FFFC},
    '{1'b0, 20'h80000, 32'h0,        1'b1, 25'h280000,  32'h5A280000},
    '{1'b1, 20'hFFFFC, 32'h00001234, 1'b1, 25'h2FFFFC,  32'h0},
    '{1'b1, 20'h0310C, 32'h8000003F, 1'b0, 25'h0,       32'h0},
    '{1'b0, 20'h80040, 32'h0,        1'b1, 25'h1F80040, 32'h5BF80040},
    '{1'b1, 20'h0310C, 32'hFFFFFFC2, 1'b0, 25'h0,       32'h0},
    '{1'b0, 20'h0310C, 32'h0,        1'b0, 25'h0,       32'h80000002},
    '{1'b0, 20'h80004, 32'h0,        1'b1, 25'h100004,  32'h5A100004},
    '{1'b1, 20'h00100, 32'hCAFEF00D, 1'b1, 25'h100,     32'h0}
  };

  initial begin
    while (cycles < 50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(h_ready == 1'b1 && i_valid == 1'b0 && h_rsp_valid == 1'b0, "R1 idle outputs",
        {29'h0, h_ready, i_valid, h_rsp_valid}, 32'h4);
    chk(blk_err == 1'b0, "R1 err clear", {31'h0, blk_err}, 32'h0);
    access(1'b0, 20'h0310C, 32'h0, rd);
    chk(rd == 32'h0, "R1 window reset value", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      c0 = fwd_cnt;
      access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd);
      @(negedge clk);
      if (!VECS[i].fwd)             tag = "R4";
      else if (i == 7 || i == 10)   tag = "R5";
      else if (VECS[i].addr[19])    tag = "R3";
      else                          tag = "R2";
      chk(rd == VECS[i].erd, {tag, " rsp data"}, rd, VECS[i].erd);
      if (VECS[i].fwd) begin
        chk(fwd_cnt == c0 + 1, {tag, " forwarded once"}, fwd_cnt, c0 + 1);
        chk(last_addr == VECS[i].eaddr, {tag, " internal addr"}, {7'h0, last_addr},
            {7'h0, VECS[i].eaddr});
        chk(last_we == VECS[i].we, "R8 write flag", {31'h0, last_we}, {31'h0, VECS[i].we});
        if (VECS[i].we)
          chk(last_wdata == VECS[i].wdata, "R8 write data", last_wdata, VECS[i].wdata);
      end else begin
        chk(fwd_cnt == c0, "R4 window reg not forwarded", fwd_cnt, c0);
      end
    end

    // R7: busy window around one request
    @(negedge clk);
    h_valid = 1'b1; h_we = 1'b0; h_addr = 20'h00040;
    @(negedge clk);
    h_valid = 1'b0;
    chk(h_ready == 1'b0, "R7 ready low after accept", {31'h0, h_ready}, 32'h0);
    while (!h_rsp_valid) begin
      chk(h_ready == 1'b0, "R7 ready low while pending", {31'h0, h_ready}, 32'h0);
      @(negedge clk);
    end
    chk(h_rsp_rdata == 32'h5A000040, "R8 read data", h_rsp_rdata, 32'h5A000040);
    @(negedge clk);
    chk(h_ready == 1'b1 && h_rsp_valid == 1'b0, "R7 ready after pulse",
        {30'h0, h_ready, h_rsp_valid}, 32'h2);

    // R6: window disabled
    access(1'b1, 20'h0310C, 32'h00000007, rd);
    c0 = fwd_cnt;
    access(1'b0, 20'h90000, 32'h0, rd);
    @(negedge clk);
    chk(rd == 32'hDEADBEEF, "R6 blocked read data", rd, 32'hDEADBEEF);
    chk(fwd_cnt == c0, "R6 blocked read not forwarded", fwd_cnt, c0);
    chk(blk_err == 1'b1, "R6 err set", {31'h0, blk_err}, 32'h1);
    access(1'b1, 20'hA0000, 32'h11112222, rd);
    @(negedge clk);
    chk(fwd_cnt == c0, "R6 blocked write dropped", fwd_cnt, c0);
    access(1'b0, 20'h0310C, 32'h0, rd);
    chk(rd == 32'h00000007, "R4 readback enable clear", rd, 32'h7);
    access(1'b0, 20'h00020, 32'h0, rd);
    chk(rd == 32'h5A000020, "R2 lower half with window off", rd, 32'h5A000020);
    chk(blk_err == 1'b1, "R6 err sticky", {31'h0, blk_err}, 32'h1);
    chk(hold_err == 0, "R9 request held under stall", hold_err, 0);

    // R1: reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(blk_err == 1'b0, "R1 err cleared by reset", {31'h0, blk_err}, 32'h0);
    access(1'b0, 20'h0310C, 32'h0, rd);
    chk(rd == 32'h0, "R1 window cleared by reset", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule